// File: doc/BRIEF.md
# RS485 Transmit Direction Controller

This block turns the transmit activity of a small UART into a driver-enable signal for an RS485 transceiver, so no software has to switch the line direction. A byte written to the data register moves the direction pin to its transmit level at once. The serial start bit follows exactly one bit period later, which gives the transceiver time to turn its driver on. After the transmit shifter runs dry, the pin stays at the transmit level for three more bit periods. This lets the stop bit clear the transceiver before the pin returns to receive.

The block includes a plain 8N1 transmit shifter with a single holding register, so it can be used and tested on its own. It also includes a bit-rate tick generator. The tick generator divides the clock by the programmed divisor times an oversampling factor of 16 or 13. Software sets an enable flag, a polarity flag, the rate mode and a 16-bit divisor through a byte-wide synchronous register port.

Top module: `rs485_autodir`

## Requirements
- R1: After reset every register reads 0, `txd` is high and `dir_out` is high (the receive level for polarity 0).
- R2: Register map. Address 1 holds divisor bits 7:0 and address 2 holds divisor bits 15:8. Address 3 is the control byte: bit 0 enables direction control, bit 1 selects polarity, bit 2 selects 13x mode. All eight bits of address 3 read back as written. `reg_rdata` shows the addressed register one clock after the address is presented. Address 0 reads as 0.
- R3: With enable set, a write to address 0 moves `dir_out` to the transmit level on the same clock edge that captures the write.
- R4: When the shifter is idle, the start bit (low) begins exactly one bit period after the edge that captures the data write. It is followed by 8 data bits, LSB first, and one high stop bit, each one bit period long.
- R5: The stop bit ends and the shifter becomes empty. `dir_out` then keeps the transmit level for exactly three more bit periods and returns to receive on the edge that ends the third.
- R6: With polarity 0, `dir_out` is low while transmitting and high at receive. With polarity 1 the levels are the other way round.
- R7: While enable is clear, `dir_out` stays at the receive level whatever the shifter is doing.
- R8: One bit period is divisor×16 clocks when control bit 2 is 0, and divisor×13 clocks when it is 1.
- R9: A data write during the three-period hold cancels the hold. `dir_out` stays at the transmit level, and the new start bit begins one bit period after the write.
- R10: A byte written while a frame is shifting starts right after that frame's stop bit. `dir_out` stays at the transmit level across both frames without a gap.
- R11: With a divisor of 0, no bit tick occurs and data writes are discarded. `txd` stays high and `dir_out` stays at the receive level, even after a nonzero divisor is loaded later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| txd | output | 1 | Serial transmit line, idle high |
| dir_out | output | 1 | Transceiver direction pin |

## Verification
The assertions assume that reset is high from time zero and that at most one byte waits in the holding register at any time. They also assume that the divisor and rate mode stay unchanged while a frame is on the line, because the tick window is only checked against the live limit. The stimulus follows this: it writes at most one extra byte during a running frame, and it reprograms the divisor, mode and polarity only after the direction pin has returned to receive.

// File: rtl/rs485dir_pkg.sv
package rs485dir_pkg;
  localparam int REG_AW = 2;
  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] A_TXDATA = 2'd0;
  localparam logic [REG_AW-1:0] A_DIVLO  = 2'd1;
  localparam logic [REG_AW-1:0] A_DIVHI  = 2'd2;
  localparam logic [REG_AW-1:0] A_CTRL   = 2'd3;

  localparam int C_ENABLE = 0;
  localparam int C_POL    = 1;
  localparam int C_OS13   = 2;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485dir_regs.sv
module rs485dir_regs
  import rs485dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic              ctl_en,
  output logic              ctl_pol,
  output logic              ctl_os13,
  output logic              data_wr,
  output logic [BYTE_W-1:0] data_byte
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] div_lo_q;
  logic [BYTE_W-1:0] div_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  ctrl_q   <= reg_wdata;
        A_DIVLO: div_lo_q <= reg_wdata;
        A_DIVHI: div_hi_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_q;
        A_DIVLO: reg_rdata <= div_lo_q;
        A_DIVHI: reg_rdata <= div_hi_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign divisor   = {div_hi_q, div_lo_q};
  assign ctl_en    = ctrl_q[C_ENABLE];
  assign ctl_pol   = ctrl_q[C_POL];
  assign ctl_os13  = ctrl_q[C_OS13];
  assign data_wr   = reg_wr && (reg_addr == A_TXDATA);
  assign data_byte = reg_wdata;
endmodule

// File: rtl/rs485dir_tick.sv
module rs485dir_tick
  import rs485dir_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             os13,
  input  logic             restart,
  output logic             tick,
  output logic             rate_ok
);
  localparam int CNT_W = DIV_W + $clog2(OS_HI) + 1;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;

  assign limit   = os13 ? CNT_W'(divisor) * CNT_W'(OS_LO)
                        : CNT_W'(divisor) * CNT_W'(OS_HI);
  assign rate_ok = (divisor != '0);
  assign tick    = rate_ok && (count >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || tick || !rate_ok) count <= '0;
    else                                   count <= count + CNT_W'(1);
  end

  // R8: every tick closes a window; the next one starts counting from zero
  a_r8_tick_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == '0));
endmodule

// File: rtl/rs485dir_shifter.sv
module rs485dir_shifter
  import rs485dir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              txd,
  output logic              busy,
  output logic              empty_evt
);
  localparam int FRAME_BITS = BYTE_W + 2;
  localparam int BC_W       = $clog2(FRAME_BITS);

  logic [BYTE_W-1:0] hold_byte;
  logic              hold_full;
  logic [BYTE_W:0]   shreg;
  logic [BC_W-1:0]   bits_left;
  logic              last_bit;

  assign last_bit  = busy && (bits_left == '0);
  assign empty_evt = tick && last_bit && !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b1;
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else begin
      if (tick) begin
        if (!busy || last_bit) begin
          if (hold_full) begin
            txd       <= 1'b0;
            shreg     <= {1'b1, hold_byte};
            bits_left <= BC_W'(FRAME_BITS - 1);
            busy      <= 1'b1;
            hold_full <= 1'b0;
          end else begin
            txd  <= 1'b1;
            busy <= 1'b0;
          end
        end else begin
          txd       <= shreg[0];
          shreg     <= {1'b1, shreg[BYTE_W:1]};
          bits_left <= bits_left - BC_W'(1);
        end
      end
      if (load) begin
        hold_byte <= load_byte;
        hold_full <= 1'b1;
      end
    end
  end

  // R4: the line only moves on a bit tick
  a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(tick));
endmodule

// File: rtl/rs485dir_fsm.sv
module rs485dir_fsm
  import rs485dir_pkg::*;
#(
  parameter int HOLD_BITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol,
  input  logic tick,
  input  logic accept,
  input  logic empty_evt,
  output logic tx_active,
  output logic dir_out
);
  localparam int HC_W = $clog2(HOLD_BITS + 1);

  dir_state_e      state, nxt;
  logic [HC_W-1:0] hold_cnt, hold_nxt;

  always_comb begin
    nxt      = state;
    hold_nxt = hold_cnt;
    if (!en) begin
      nxt      = DIR_IDLE;
      hold_nxt = '0;
    end else if (accept) begin
      nxt      = DIR_SEND;
      hold_nxt = '0;
    end else begin
      case (state)
        DIR_SEND: if (empty_evt) begin
          nxt      = DIR_HOLD;
          hold_nxt = '0;
        end
        DIR_HOLD: if (tick) begin
          if (hold_cnt == HC_W'(HOLD_BITS - 1)) begin
            nxt      = DIR_IDLE;
            hold_nxt = '0;
          end else begin
            hold_nxt = hold_cnt + HC_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= DIR_IDLE;
      hold_cnt <= '0;
      dir_out  <= 1'b1;
    end else begin
      state    <= nxt;
      hold_cnt <= hold_nxt;
      dir_out  <= (nxt == DIR_IDLE) ? ~pol : pol;
    end
  end

  assign tx_active = (state != DIR_IDLE);

  // R7: a cleared enable forces receive by the next cycle
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tx_active);
  // R3: an accepted write with enable set means transmit on the next cycle
  a_r3_write_activates: assert property (@(posedge clk) disable iff (rst)
    (accept && en) |=> tx_active);
  // R5: the hold never counts past its fixed length
  a_r5_hold_bounded: assert property (@(posedge clk) disable iff (rst)
    (state == DIR_HOLD) |-> (hold_cnt < HC_W'(HOLD_BITS)));
endmodule

// File: rtl/rs485_autodir.sv
module rs485_autodir
  import rs485dir_pkg::*;
#(
  parameter int HOLD_BITS = 3,
  parameter int OS_HI     = 16,
  parameter int OS_LO     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              txd,
  output logic              dir_out
);
  logic [DIV_W-1:0]  divisor;
  logic              ctl_en, ctl_pol, ctl_os13;
  logic              data_wr;
  logic [BYTE_W-1:0] data_byte;
  logic              tick, rate_ok;
  logic              accept, restart;
  logic              busy, empty_evt;
  logic              tx_active;

  assign accept  = data_wr && rate_ok;
  assign restart = accept && !busy;

  rs485dir_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .divisor   (divisor),
    .ctl_en    (ctl_en),
    .ctl_pol   (ctl_pol),
    .ctl_os13  (ctl_os13),
    .data_wr   (data_wr),
    .data_byte (data_byte)
  );

  rs485dir_tick #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .os13    (ctl_os13),
    .restart (restart),
    .tick    (tick),
    .rate_ok (rate_ok)
  );

  rs485dir_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (accept),
    .load_byte (data_byte),
    .txd       (txd),
    .busy      (busy),
    .empty_evt (empty_evt)
  );

  rs485dir_fsm #(.HOLD_BITS(HOLD_BITS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl_en),
    .pol       (ctl_pol),
    .tick      (tick),
    .accept    (accept),
    .empty_evt (empty_evt),
    .tx_active (tx_active),
    .dir_out   (dir_out)
  );

  // R6: pin level follows the direction state and the polarity in force
  a_r6_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dir_out == (tx_active ? $past(ctl_pol) : ~$past(ctl_pol))));
  // R11: with no rate, nothing is accepted and the line stays idle
  a_r11_no_rate_no_send: assert property (@(posedge clk) disable iff (rst)
    (!rate_ok && !busy) |=> txd);
endmodule

// File: tb/rs485_autodir_tb.sv
`timescale 1ns/1ps
module rs485_autodir_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd3;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txd, dir_out;

  int checks = 0;
  int fails  = 0;
  int el     = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rs485_autodir u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd), .dir_out(dir_out)
  );

  // vector: {div[7:0], os13, pol, en, data[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {8'd1, 1'b0, 1'b0, 1'b1, 8'hA5},
    {8'd1, 1'b1, 1'b1, 1'b1, 8'h3C},
    {8'd2, 1'b0, 1'b1, 1'b1, 8'h81},
    {8'd2, 1'b1, 1'b0, 1'b1, 8'h5E},
    {8'd1, 1'b0, 1'b0, 1'b0, 8'hC3},
    {8'd1, 1'b1, 1'b1, 1'b0, 8'h0F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at el=%0d", req, act, exp, el);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    reg_addr = 2'd3;
  endtask

  task automatic adv(input int target);
    while (el < target) begin
      @(negedge clk);
      el++;
    end
  endtask

  task automatic send(input logic [7:0] d);
    wr(2'd0, d);
    el = 0;
  endtask

  task automatic check_bits(input int base, input int p, input logic [7:0] d, input string req);
    for (int i = 1; i <= 9; i++) begin
      adv(base + p * (1 + i) + p / 2);
      check(req, {7'd0, txd}, (i <= 8) ? {7'd0, d[i-1]} : 8'd1);
    end
  endtask

  task automatic cfg(input logic [7:0] dv, input logic os13, input logic pol, input logic en);
    wr(2'd1, dv);
    wr(2'd2, 8'd0);
    wr(2'd3, {5'd0, os13, pol, en});
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p, act, idl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 txd", {7'd0, txd}, 8'd1);
    check("R1 dir", {7'd0, dir_out}, 8'd1);
    rd(2'd3, v); check("R1 ctrl", v, 8'd0);
    rd(2'd1, v); check("R1 divlo", v, 8'd0);

    // R2 readback
    wr(2'd3, 8'hF8); rd(2'd3, v); check("R2 ctrl", v, 8'hF8);
    wr(2'd1, 8'h9A); rd(2'd1, v); check("R2 divlo", v, 8'h9A);
    wr(2'd2, 8'h01); rd(2'd2, v); check("R2 divhi", v, 8'h01);
    rd(2'd0, v); check("R2 data reads 0", v, 8'h00);

    // table walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[k]) begin
      p   = VEC[k][10] ? 13 * VEC[k][18:11] : 16 * VEC[k][18:11];
      act = VEC[k][8] ? (VEC[k][9] ? 1 : 0) : (VEC[k][9] ? 0 : 1);
      idl = VEC[k][9] ? 0 : 1;
      cfg(VEC[k][18:11], VEC[k][10], VEC[k][9], VEC[k][8]);
      check("R6 idle level", {7'd0, dir_out}, 8'(idl));
      send(VEC[k][7:0]);
      check(VEC[k][8] ? "R3 dir on write" : "R7 dir stays", {7'd0, dir_out}, 8'(act));
      adv(p - 1); check("R4 lead", {7'd0, txd}, 8'd1);
      adv(p);     check("R4 start", {7'd0, txd}, 8'd0);
      check("R6 send level", {7'd0, dir_out}, 8'(act));
      check_bits(0, p, VEC[k][7:0], "R8 bit");
      adv(14 * p - 1); check("R5 hold", {7'd0, dir_out}, 8'(act));
      adv(14 * p);     check("R5 release", {7'd0, dir_out}, 8'(idl));
    end

    // R9 write during the hold window
    cfg(8'd1, 1'b0, 1'b1, 1'b1);
    p = 16;
    send(8'h12);
    adv(12 * p + 3);
    check("R9 in hold", {7'd0, dir_out}, 8'd1);
    wr(2'd0, 8'h34); el = el + 2;
    begin
      int b;
      b = el;
      check("R9 stays send", {7'd0, dir_out}, 8'd1);
      adv(b + p - 1); check("R9 lead", {7'd0, txd}, 8'd1);
      adv(b + p);     check("R9 start", {7'd0, txd}, 8'd0);
      check_bits(b, p, 8'h34, "R9 bit");
      adv(b + 14 * p); check("R9 release", {7'd0, dir_out}, 8'd0);
    end

    // R10 back-to-back frames
    cfg(8'd1, 1'b0, 1'b0, 1'b1);
    send(8'hE7);
    adv(2 * p - 1);
    wr(2'd0, 8'h69); el = el + 2;
    adv(11 * p - 1); check("R10 stop of first", {7'd0, txd}, 8'd1);
    adv(11 * p);     check("R10 next start", {7'd0, txd}, 8'd0);
    check_bits(10 * p, p, 8'h69, "R10 bit");
    adv(14 * p); check("R10 no gap", {7'd0, dir_out}, 8'd0);
    adv(24 * p - 1); check("R10 hold", {7'd0, dir_out}, 8'd0);
    adv(24 * p);     check("R10 release", {7'd0, dir_out}, 8'd1);

    // R11 divisor zero
    cfg(8'd0, 1'b0, 1'b1, 1'b1);
    send(8'h55);
    check("R11 dir", {7'd0, dir_out}, 8'd0);
    for (int j = 1; j <= 4; j++) begin
      adv(j * 40);
      check("R11 txd", {7'd0, txd}, 8'd1);
      check("R11 dir", {7'd0, dir_out}, 8'd0);
    end
    wr(2'd1, 8'd1);
    el = 0;
    for (int j = 1; j <= 6; j++) begin
      adv(j * 40);
      check("R11 dropped byte", {7'd0, txd}, 8'd1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule